// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Unit

This unit sits beside a processor core and watches its local bus for debug breakpoints. It has two independent channels, A and B. Each channel is set up either to watch executed instructions or to watch data accesses. For each channel it drives a one-cycle break request pulse toward the core.

Instruction breakpoints are checked at execution boundaries. The core presents each instruction that really starts executing, together with its fetch address and its pipeline status: whether it sits in a delay slot and whether it is a SLEEP instruction. Instructions fetched ahead and then discarded are never presented, so they can never trigger a break.

A channel can break either before the matching instruction runs or after it completes. When the break cannot be taken at once, it is held in a per-channel pending flag. It is then delivered at the first later boundary whose instruction can accept a break. Data breakpoints compare the access address, with a width that depends on the access size, as well as the access direction and size. Channel B also compares the data value.

Top module: `brk_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `brk_a` and `brk_b` are low, and no pending break survives reset.
- R2: A channel whose kind is fetch (`cfg_kind_x`=0) matches only an executed instruction whose `ix_pc` equals `cfg_addr_x` exactly. If bit 0 of `cfg_addr_x` is 1, that channel never raises a break.
- R3: A fetch channel with `cfg_after_x`=0 that matches at a boundary (`ix_go`=1) with `ix_slot`=0 pulses its break output high for exactly the cycle after that boundary.
- R4: A fetch-kind channel raises breaks only in the cycle after a boundary with `ix_go`=1 and `ix_slot`=0. Cycles with `ix_go`=0 never match, whatever `ix_pc` holds.
- R5: A before-execution match on an instruction with `ix_slot`=1 gives no break at that boundary. Instead, the break is raised after the next boundary with `ix_go`=1 and `ix_slot`=0.
- R6: An after-execution match (`cfg_after_x`=1) never breaks at its own boundary. The break is raised after the next later boundary with `ix_slot`=0. This means that a delayed branch match skips past its delay slot.
- R7: An after-execution match on an instruction with `ix_sleep`=1 never produces a break.
- R8: In a cycle with `cfg_wr_x`=1, channel x raises no break in the following cycle, and any pending break of that channel is discarded. Configuration is changed only together with this strobe.
- R9: A data-kind channel (`cfg_kind_x`=1) compares addresses by size. The size encoding is 0 byte, 1 word, 2 longword, 3 reserved. Byte compares bits 31..0, word compares bits 31..1, and longword compares bits 31..2. Size 3 never matches, and a cycle with `da_valid`=0 never matches.
- R10: A data match also requires `da_write` to equal `cfg_onwr_x` and `da_size` to equal `cfg_size_x`. The break pulse follows in the next cycle.
- R11: In data kind, channel B additionally requires `da_data` to equal `cfg_data_b`. In fetch kind, `cfg_data_b` and `da_data` have no effect on channel B.
- R12: The channels act independently. Both break outputs can pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_a | input | 1 | Channel A configuration rewrite strobe |
| cfg_kind_a | input | 1 | Channel A kind: 0 fetch, 1 data |
| cfg_onwr_a | input | 1 | Channel A data direction: 0 read, 1 write |
| cfg_size_a | input | 2 | Channel A data size code |
| cfg_after_a | input | 1 | Channel A fetch timing: 0 before, 1 after execution |
| cfg_addr_a | input | AW | Channel A break address |
| cfg_wr_b | input | 1 | Channel B configuration rewrite strobe |
| cfg_kind_b | input | 1 | Channel B kind: 0 fetch, 1 data |
| cfg_onwr_b | input | 1 | Channel B data direction |
| cfg_size_b | input | 2 | Channel B data size code |
| cfg_after_b | input | 1 | Channel B fetch timing |
| cfg_addr_b | input | AW | Channel B break address |
| cfg_data_b | input | DW | Channel B break data value |
| ix_go | input | 1 | An instruction starts executing this cycle |
| ix_pc | input | AW | Fetch address of that instruction |
| ix_slot | input | 1 | That instruction is in a delay slot |
| ix_sleep | input | 1 | That instruction is SLEEP |
| da_valid | input | 1 | Data access cycle present |
| da_write | input | 1 | Data access is a write |
| da_size | input | 2 | Data access size code |
| da_addr | input | AW | Data access address |
| da_data | input | DW | Data access value |
| brk_a | output | 1 | Channel A break request pulse |
| brk_b | output | 1 | Channel B break request pulse |

## Verification
The bench builds the unit with its default widths: 32-bit addresses and 32-bit data. At these widths, the size-dependent masking of the low two address bits is the real boundary case. The random part draws fetch addresses and break addresses from a pool of a few even and odd values, so exact hits, odd-address lockouts and delay-slot deferrals occur often. Data addresses are drawn from a narrow window, so word and longword matches on unaligned low bits are exercised repeatedly, alongside the directed cases.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic {
        KIND_FETCH = 1'b0,
        KIND_DATA  = 1'b1
    } brk_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_NONE = 2'd3
    } brk_size_e;

    typedef struct packed {
        brk_kind_e kind;
        logic      on_write;
        brk_size_e size;
        logic      after_exec;
    } brk_ctl_t;

    // number of low address bits left out of a data compare
    function automatic int unsigned ignored_lsbs(input brk_size_e s);
        case (s)
            SZ_WORD: return 1;
            SZ_LONG: return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/brk_fetch_qual.sv
module brk_fetch_qual
    import brk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          is_fetch,
    input  logic          after_exec,
    input  logic [AW-1:0] cfg_addr,
    input  logic          cfg_wr,
    input  logic          ix_go,
    input  logic [AW-1:0] ix_pc,
    input  logic          ix_slot,
    input  logic          ix_sleep,
    output logic          fire
);
    logic pend_q;
    logic hit, accept, now, set_pend;

    always_comb begin
        hit      = is_fetch && !cfg_addr[0] && ix_go && (ix_pc == cfg_addr);
        accept   = ix_go && !ix_slot;
        now      = hit && !after_exec && !ix_slot;
        set_pend = hit && (after_exec ? !ix_sleep : ix_slot);
        fire     = !cfg_wr && (now || (pend_q && accept));
    end

    always_ff @(posedge clk) begin
        if (rst || cfg_wr) pend_q <= 1'b0;
        else               pend_q <= (pend_q && !accept) || set_pend;
    end

endmodule

// File: rtl/brk_data_cmp.sv
module brk_data_cmp
    import brk_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter bit HAS_DATA = 1'b0
) (
    input  brk_ctl_t      ctl,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_data,
    input  logic          da_valid,
    input  logic          da_write,
    input  brk_size_e     da_size,
    input  logic [AW-1:0] da_addr,
    input  logic [DW-1:0] da_data,
    output logic          hit
);
    logic [AW-1:0] cmp_mask;
    logic          addr_ok, data_ok, kind_ok;

    always_comb begin
        cmp_mask = {AW{1'b1}} << ignored_lsbs(da_size);
        addr_ok  = ((da_addr ^ cfg_addr) & cmp_mask) == '0;
        data_ok  = (HAS_DATA == 1'b0) || (da_data == cfg_data);
        kind_ok  = (ctl.kind == KIND_DATA) && (ctl.on_write == da_write)
                && (ctl.size == da_size) && (da_size != SZ_NONE);
        hit      = da_valid && kind_ok && addr_ok && data_ok;
    end

endmodule

// File: rtl/brk_channel.sv
module brk_channel
    import brk_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter bit HAS_DATA = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  brk_ctl_t      ctl,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_data,
    input  logic          cfg_wr,
    input  logic          ix_go,
    input  logic [AW-1:0] ix_pc,
    input  logic          ix_slot,
    input  logic          ix_sleep,
    input  logic          da_valid,
    input  logic          da_write,
    input  brk_size_e     da_size,
    input  logic [AW-1:0] da_addr,
    input  logic [DW-1:0] da_data,
    output logic          brk
);
    logic fetch_fire, data_hit;

    brk_fetch_qual #(.AW(AW)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .is_fetch   (ctl.kind == KIND_FETCH),
        .after_exec (ctl.after_exec),
        .cfg_addr   (cfg_addr),
        .cfg_wr     (cfg_wr),
        .ix_go      (ix_go),
        .ix_pc      (ix_pc),
        .ix_slot    (ix_slot),
        .ix_sleep   (ix_sleep),
        .fire       (fetch_fire)
    );

    brk_data_cmp #(.AW(AW), .DW(DW), .HAS_DATA(HAS_DATA)) u_data (
        .ctl      (ctl),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .da_valid (da_valid),
        .da_write (da_write),
        .da_size  (da_size),
        .da_addr  (da_addr),
        .da_data  (da_data),
        .hit      (data_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) brk <= 1'b0;
        else     brk <= !cfg_wr && (fetch_fire || data_hit);
    end

endmodule

// File: rtl/brk_unit.sv
module brk_unit
    import brk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr_a,
    input  logic          cfg_kind_a,
    input  logic          cfg_onwr_a,
    input  logic [1:0]    cfg_size_a,
    input  logic          cfg_after_a,
    input  logic [AW-1:0] cfg_addr_a,
    input  logic          cfg_wr_b,
    input  logic          cfg_kind_b,
    input  logic          cfg_onwr_b,
    input  logic [1:0]    cfg_size_b,
    input  logic          cfg_after_b,
    input  logic [AW-1:0] cfg_addr_b,
    input  logic [DW-1:0] cfg_data_b,
    input  logic          ix_go,
    input  logic [AW-1:0] ix_pc,
    input  logic          ix_slot,
    input  logic          ix_sleep,
    input  logic          da_valid,
    input  logic          da_write,
    input  logic [1:0]    da_size,
    input  logic [AW-1:0] da_addr,
    input  logic [DW-1:0] da_data,
    output logic          brk_a,
    output logic          brk_b
);
    localparam int NCH = 2;

    brk_ctl_t      ctl  [NCH];
    logic [AW-1:0] addr [NCH];
    logic [DW-1:0] bval [NCH];
    logic          wr   [NCH];
    logic          brk  [NCH];

    always_comb begin
        ctl[0]  = '{kind: brk_kind_e'(cfg_kind_a), on_write: cfg_onwr_a,
                    size: brk_size_e'(cfg_size_a), after_exec: cfg_after_a};
        ctl[1]  = '{kind: brk_kind_e'(cfg_kind_b), on_write: cfg_onwr_b,
                    size: brk_size_e'(cfg_size_b), after_exec: cfg_after_b};
        addr[0] = cfg_addr_a;
        addr[1] = cfg_addr_b;
        bval[0] = '0;
        bval[1] = cfg_data_b;
        wr[0]   = cfg_wr_a;
        wr[1]   = cfg_wr_b;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        brk_channel #(.AW(AW), .DW(DW), .HAS_DATA(i == 1)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .ctl      (ctl[i]),
            .cfg_addr (addr[i]),
            .cfg_data (bval[i]),
            .cfg_wr   (wr[i]),
            .ix_go    (ix_go),
            .ix_pc    (ix_pc),
            .ix_slot  (ix_slot),
            .ix_sleep (ix_sleep),
            .da_valid (da_valid),
            .da_write (da_write),
            .da_size  (brk_size_e'(da_size)),
            .da_addr  (da_addr),
            .da_data  (da_data),
            .brk      (brk[i])
        );
    end

    assign brk_a = brk[0];
    assign brk_b = brk[1];

endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_wr_a,
    input logic          cfg_kind_a,
    input logic          cfg_onwr_a,
    input logic [AW-1:0] cfg_addr_a,
    input logic          cfg_wr_b,
    input logic          cfg_kind_b,
    input logic [AW-1:0] cfg_addr_b,
    input logic [DW-1:0] cfg_data_b,
    input logic          ix_go,
    input logic          ix_slot,
    input logic          da_valid,
    input logic          da_write,
    input logic [1:0]    da_size,
    input logic [DW-1:0] da_data,
    input logic          brk_a,
    input logic          brk_b
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!brk_a && !brk_b));

    assert_odd_addr_a_R2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_kind_a && cfg_addr_a[0]) |=> !brk_a);

    assert_odd_addr_b_R2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_kind_b && cfg_addr_b[0]) |=> !brk_b);

    assert_boundary_only_a_R4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_kind_a && !(ix_go && !ix_slot)) |=> !brk_a);

    assert_boundary_only_b_R4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_kind_b && !(ix_go && !ix_slot)) |=> !brk_b);

    assert_rewrite_a_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_a |=> !brk_a);

    assert_rewrite_b_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_b |=> !brk_b);

    assert_data_idle_a_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_kind_a && (!da_valid || da_size == 2'd3)) |=> !brk_a);

    assert_direction_a_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_kind_a && da_write != cfg_onwr_a) |=> !brk_a);

    assert_bvalue_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_kind_b && da_data != cfg_data_b) |=> !brk_b);

endmodule

bind brk_unit brk_unit_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_brk_unit.sv
`timescale 1ns/1ps
module tb_brk_unit;
    localparam int AW = 32;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          c_wr   [2];
    logic          c_kind [2];
    logic          c_onwr [2];
    logic [1:0]    c_size [2];
    logic          c_aft  [2];
    logic [AW-1:0] c_addr [2];
    logic [DW-1:0] c_bdat;
    logic          ix_go, ix_slot, ix_sleep;
    logic [AW-1:0] ix_pc;
    logic          da_valid, da_write;
    logic [1:0]    da_size;
    logic [AW-1:0] da_addr;
    logic [DW-1:0] da_data;
    logic          brk_a, brk_b;

    brk_unit #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst(rst),
        .cfg_wr_a(c_wr[0]), .cfg_kind_a(c_kind[0]), .cfg_onwr_a(c_onwr[0]),
        .cfg_size_a(c_size[0]), .cfg_after_a(c_aft[0]), .cfg_addr_a(c_addr[0]),
        .cfg_wr_b(c_wr[1]), .cfg_kind_b(c_kind[1]), .cfg_onwr_b(c_onwr[1]),
        .cfg_size_b(c_size[1]), .cfg_after_b(c_aft[1]), .cfg_addr_b(c_addr[1]),
        .cfg_data_b(c_bdat),
        .ix_go(ix_go), .ix_pc(ix_pc), .ix_slot(ix_slot), .ix_sleep(ix_sleep),
        .da_valid(da_valid), .da_write(da_write), .da_size(da_size),
        .da_addr(da_addr), .da_data(da_data),
        .brk_a(brk_a), .brk_b(brk_b)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    logic m_pend [2];

    function automatic logic [AW-1:0] size_mask(input logic [1:0] s);
        if (s == 2'd1) return 32'hFFFF_FFFE;
        if (s == 2'd2) return 32'hFFFF_FFFC;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic data_match(input int ch);
        logic ok;
        ok = c_kind[ch] && da_valid && (da_write == c_onwr[ch])
          && (da_size == c_size[ch]) && (da_size != 2'd3)
          && (((da_addr ^ c_addr[ch]) & size_mask(da_size)) == '0);
        if (ch == 1) ok = ok && (da_data == c_bdat);
        return ok;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string nm);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, nm, act, exp, $time);
        end
    endtask

    // one clock: model from inputs seen at the edge, then compare outputs
    task automatic tick(input string tag);
        logic e [2];
        @(posedge clk);
        for (int ch = 0; ch < 2; ch++) begin
            logic fh, acc;
            fh  = !c_kind[ch] && !c_addr[ch][0] && ix_go && (ix_pc == c_addr[ch]);
            acc = ix_go && !ix_slot;
            if (rst || c_wr[ch]) begin
                e[ch] = 1'b0;
                m_pend[ch] = 1'b0;
            end else begin
                e[ch] = (fh && !c_aft[ch] && !ix_slot) || (m_pend[ch] && acc) || data_match(ch);
                m_pend[ch] = (m_pend[ch] && !acc) || (fh && (c_aft[ch] ? !ix_sleep : ix_slot));
            end
        end
        #1;
        check(tag, brk_a, e[0], "brk_a");
        check(tag, brk_b, e[1], "brk_b");
        @(negedge clk);
    endtask

    task automatic setcfg(input int ch, input logic kind, input logic onwr,
                          input logic [1:0] sz, input logic aft, input logic [AW-1:0] a,
                          input string tag);
        c_kind[ch] = kind; c_onwr[ch] = onwr; c_size[ch] = sz;
        c_aft[ch] = aft; c_addr[ch] = a; c_wr[ch] = 1'b1;
        tick(tag);
        c_wr[ch] = 1'b0;
    endtask

    task automatic bnd(input logic [AW-1:0] pc, input logic slot, input logic slp,
                       input string tag);
        ix_go = 1'b1; ix_pc = pc; ix_slot = slot; ix_sleep = slp;
        tick(tag);
        ix_go = 1'b0; ix_slot = 1'b0; ix_sleep = 1'b0;
    endtask

    task automatic dacc(input logic wrt, input logic [1:0] sz, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string tag);
        da_valid = 1'b1; da_write = wrt; da_size = sz; da_addr = a; da_data = d;
        tick(tag);
        da_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        for (int ch = 0; ch < 2; ch++) begin
            c_wr[ch] = 0; c_kind[ch] = 0; c_onwr[ch] = 0; c_size[ch] = 0;
            c_aft[ch] = 0; c_addr[ch] = 32'h1; m_pend[ch] = 0;
        end
        c_bdat = 0; ix_go = 0; ix_pc = 0; ix_slot = 0; ix_sleep = 0;
        da_valid = 0; da_write = 0; da_size = 0; da_addr = 0; da_data = 0;
        @(negedge clk);
        tick("R1 in reset");
        tick("R1 in reset");
        rst = 1'b0;
        tick("R1 after reset");

        // R3 before-execution break
        setcfg(0, 0, 0, 0, 0, 32'h100, "R3 cfg");
        bnd(32'h100, 0, 0, "R3 immediate break");
        bnd(32'h104, 0, 0, "R3 no hit");
        // R2 odd address lockout
        setcfg(0, 0, 0, 0, 0, 32'h101, "R2 cfg");
        bnd(32'h101, 0, 0, "R2 odd address blocked");
        bnd(32'h100, 0, 0, "R2 exact compare only");
        // R4 no boundary, no break
        setcfg(0, 0, 0, 0, 0, 32'h100, "R4 cfg");
        ix_pc = 32'h100; tick("R4 pc without ix_go");
        // R5 delay-slot deferral
        bnd(32'h100, 1, 0, "R5 slot held");
        bnd(32'h200, 0, 0, "R5 deferred break");
        tick("R5 single pulse");
        // R6 after execution across delayed branch
        setcfg(0, 0, 0, 0, 1, 32'h300, "R6 cfg");
        bnd(32'h300, 0, 0, "R6 not at own boundary");
        bnd(32'h304, 1, 0, "R6 slot cannot accept");
        bnd(32'h308, 0, 0, "R6 break after slot");
        // R7 sleep
        bnd(32'h300, 0, 1, "R7 sleep match");
        bnd(32'h304, 0, 0, "R7 no break after sleep");
        // R8 rewrite discards pending
        bnd(32'h300, 0, 0, "R8 pending set");
        setcfg(0, 0, 0, 0, 1, 32'h300, "R8 rewrite");
        bnd(32'h304, 0, 0, "R8 pending discarded");
        // R9 size-based address compare
        setcfg(0, 1, 0, 2, 0, 32'h1000, "R9 cfg long");
        dacc(0, 2, 32'h1003, 0, "R9 long ignores bits 1:0");
        dacc(0, 2, 32'h1004, 0, "R9 long miss");
        setcfg(0, 1, 0, 1, 0, 32'h1002, "R9 cfg word");
        dacc(0, 1, 32'h1003, 0, "R9 word ignores bit 0");
        dacc(0, 1, 32'h1001, 0, "R9 word miss");
        setcfg(0, 1, 0, 3, 0, 32'h1000, "R9 cfg reserved");
        dacc(0, 3, 32'h1000, 0, "R9 reserved size");
        // R10 direction and size
        setcfg(0, 1, 1, 0, 0, 32'h1003, "R10 cfg byte write");
        dacc(1, 0, 32'h1003, 0, "R10 byte write hit");
        dacc(0, 0, 32'h1003, 0, "R10 direction mismatch");
        dacc(1, 1, 32'h1003, 0, "R10 size mismatch");
        dacc(1, 0, 32'h1002, 0, "R10 byte needs all bits");
        // R11 channel B data value
        c_bdat = 32'hCAFE_0001;
        setcfg(1, 1, 0, 2, 0, 32'h2000, "R11 cfg");
        dacc(0, 2, 32'h2000, 32'hCAFE_0001, "R11 value hit");
        dacc(0, 2, 32'h2000, 32'hCAFE_0002, "R11 value miss");
        setcfg(1, 0, 0, 0, 0, 32'h400, "R11 fetch cfg");
        da_data = 32'h0BAD_0BAD;
        bnd(32'h400, 0, 0, "R11 value ignored for fetch");
        // R12 both channels together
        setcfg(0, 0, 0, 0, 0, 32'h400, "R12 cfg");
        bnd(32'h400, 0, 0, "R12 both pulse");

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 40) == 0) begin
                int ch = $urandom % 2;
                setcfg(ch, 1'($urandom), 1'($urandom), 2'($urandom),
                       1'($urandom), ((($urandom % 8) == 0) ? 32'h101 : 32'h100 + 2 * ($urandom % 6))
                       ^ ((c_kind[ch]) ? 32'h0 : 32'h0), "R12 random cfg");
                if (($urandom % 2) == 0) c_addr[ch] = c_addr[ch];
            end else begin
                ix_go    = (($urandom % 3) != 0);
                ix_pc    = 32'h100 + 2 * ($urandom % 6) + ((($urandom % 10) == 0) ? 1 : 0);
                ix_slot  = (($urandom % 4) == 0);
                ix_sleep = (($urandom % 8) == 0);
                da_valid = 1'($urandom);
                da_write = 1'($urandom);
                da_size  = 2'($urandom);
                da_addr  = 32'h100 + ($urandom % 12);
                da_data  = (($urandom % 2) == 0) ? c_bdat : 32'h0;
                tick("R12 random mix");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule